// File: doc/BRIEF.md
# UART Transmitter with Flow Control

This block turns words handed over by a host into asynchronous serial frames on a single transmit line. The host offers words on a valid/ready stream. A word is accepted on any clock where `s_valid` and `s_ready` are both high. `s_ready` is low exactly while the four-entry queue is full. A host that sees `s_ready` low keeps `s_valid` and `s_data` steady until it is accepted. Bit timing comes from an external baud generator. It supplies a one-clock `baud_tick` pulse once per bit time, and the line changes only on those ticks.

Each frame is a low start bit, then data least significant bit first, then an optional parity bit, then one or two high stop bits. Data is 8 bits with even, odd or no parity, or 9 bits with no parity. A clear-to-send input gates the start of every frame. It is looked at only when a frame is about to begin, so a frame that has started always finishes. Two single-cycle commands insert extra frames. One is a break: a long low period followed by a stop bit. The other is a sync character, 0x55. A level interrupt tells the host when to refill the queue, using one of two thresholds.

Top module: `uart_tx_flow`

## Requirements
- R1: After reset `tx_out` is 1, `tx_busy` is 0 and `s_ready` is 1. Whenever no frame is in progress, `tx_out` is 1.
- R2: A frame is a start bit of 0, then data bits LSB first, then stop bits of 1. Each bit lasts from one `baud_tick` to the next.
- R3: In 8-bit mode a parity bit follows the data. `cfg_parity` = 01 selects even parity, so the data bits plus the parity bit hold an even number of ones. `cfg_parity` = 10 selects odd parity. The values 00 and 11 send no parity bit.
- R4: With `cfg_nine_bit` = 1, `s_data[8]` is sent as a ninth data bit and no parity bit is sent, whatever `cfg_parity` holds.
- R5: `cfg_two_stop` = 1 appends two stop bits. `cfg_two_stop` = 0 appends one.
- R6: Up to 4 words are queued and sent in acceptance order. `s_ready` is 0 while 4 words are held.
- R7: A frame starts only on a `baud_tick` on which `cts` is 1. Dropping `cts` during a frame does not cut that frame short, and no further frame starts until `cts` is 1 again.
- R8: A `send_break` pulse makes a break frame. The break holds the line at 0 for BREAK_BITS (default 13) bit times, start bit included, and then sends one stop bit of 1.
- R9: A `send_sync` pulse makes a frame carrying 0x55 as 8-bit data. It uses the current parity and stop settings even when `cfg_nine_bit` = 1.
- R10: When several frames are waiting at a frame start, a break goes first, then a sync, then queued data. A repeated command that arrives while the same command is still waiting merges into it.
- R11: With `irq_sel` = 0, `tx_irq` is 1 while the queue has a free slot. With `irq_sel` = 1, `tx_irq` is 1 only while the queue is empty.
- R12: If another frame is waiting and `cts` is 1, its start bit begins on the tick right after the previous frame's last stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| s_valid | input | 1 | Host word valid |
| s_ready | output | 1 | Queue can accept a word |
| s_data | input | 9 | Host word; bit 8 is used only in 9-bit mode |
| cts | input | 1 | Clear to send, active high |
| cfg_nine_bit | input | 1 | 1 selects 9-bit data |
| cfg_parity | input | 2 | 00 none, 01 even, 10 odd, 11 none |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| irq_sel | input | 1 | Interrupt threshold: 0 free slot, 1 queue empty |
| send_break | input | 1 | Pulse requesting a break frame |
| send_sync | input | 1 | Pulse requesting a sync frame |
| tx_out | output | 1 | Serial transmit line |
| tx_busy | output | 1 | A frame is being shifted out |
| tx_irq | output | 1 | Transmit interrupt, level |

## Verification
Frames are captured from the line at each bit boundary and compared with frames built from the configuration. The data patterns are 0xA5, 0x01 and 0x80. They show whether bits go out LSB first, and whether a lone set bit lands at the correct end. Parity is tried with a byte of odd weight and a byte of even weight, under even, odd and the reserved setting. This separates the two parity senses from each other and from the no-parity case. Queued bursts with `cts` held low, `cts` dropped mid-frame, and break, sync and data waiting together show the gating, the ordering, the priority and the back-to-back spacing that a single frame cannot reveal.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;
  typedef enum logic [1:0] {
    SRC_DATA  = 2'd0,
    SRC_SYNC  = 2'd1,
    SRC_BREAK = 2'd2
  } src_e;

  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;
  localparam logic [7:0] SYNC_CHAR = 8'h55;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/txf_fifo.sv
module txf_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign dout  = mem[rd_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= nxt(wr_q);
      if (pop)  rd_q <= nxt(rd_q);
      if (push && !pop)      cnt_q <= cnt_q + CW'(1);
      else if (pop && !push) cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_no_pop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/txf_framer.sv
module txf_framer
  import uart_txf_pkg::*;
#(
  parameter int BREAK_BITS = 13,
  parameter int SH_W       = 13,
  parameter int CNT_W      = 4
) (
  input  src_e             src,
  input  logic [8:0]       data,
  input  logic             nine,
  input  logic [1:0]       parity,
  input  logic             two_stop,
  output logic [SH_W-1:0]  bits,
  output logic [CNT_W-1:0] len
);
  logic [7:0] byte_v;
  logic       wide, par_on, extra;

  always_comb begin
    bits   = '1;
    len    = '0;
    byte_v = (src == SRC_SYNC) ? SYNC_CHAR : data[7:0];
    wide   = (src == SRC_DATA) && nine;
    par_on = (parity == PAR_EVEN) || (parity == PAR_ODD);
    extra  = wide || par_on;
    if (src == SRC_BREAK) begin
      for (int i = 0; i < SH_W; i++)
        if (i < BREAK_BITS - 1) bits[i] = 1'b0;
      len = CNT_W'(BREAK_BITS);
    end else begin
      bits[BYTE_W-1:0] = byte_v;
      if (wide)        bits[BYTE_W] = data[8];
      else if (par_on) bits[BYTE_W] = (parity == PAR_ODD) ? ~^byte_v : ^byte_v;
      len = CNT_W'(BYTE_W) + CNT_W'(extra) + CNT_W'(1) + CNT_W'(two_stop);
    end
  end
endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow
  import uart_txf_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int BREAK_BITS = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [8:0] s_data,
  input  logic       cts,
  input  logic       cfg_nine_bit,
  input  logic [1:0] cfg_parity,
  input  logic       cfg_two_stop,
  input  logic       irq_sel,
  input  logic       send_break,
  input  logic       send_sync,
  output logic       tx_out,
  output logic       tx_busy,
  output logic       tx_irq
);
  localparam int SH_W  = (BREAK_BITS > 11) ? BREAK_BITS : 11;
  localparam int CNT_W = $clog2(SH_W + 1);

  logic             full, empty, push, pop;
  logic [8:0]       head;
  logic             brk_pend_q, sync_pend_q;
  logic             busy_q, line_q;
  logic [SH_W-1:0]  sh_q, fr_bits;
  logic [CNT_W-1:0] cnt_q, fr_len;
  logic             have_req, slot_free, start;
  src_e             src;

  assign push = s_valid && !full;

  txf_fifo #(.W(9), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push(push), .din(s_data),
    .pop(pop), .dout(head), .full(full), .empty(empty)
  );

  always_comb begin
    if (brk_pend_q)       src = SRC_BREAK;
    else if (sync_pend_q) src = SRC_SYNC;
    else                  src = SRC_DATA;
  end

  txf_framer #(.BREAK_BITS(BREAK_BITS), .SH_W(SH_W), .CNT_W(CNT_W)) framer_i (
    .src(src), .data(head), .nine(cfg_nine_bit), .parity(cfg_parity),
    .two_stop(cfg_two_stop), .bits(fr_bits), .len(fr_len)
  );

  assign have_req  = brk_pend_q || sync_pend_q || !empty;
  assign slot_free = !busy_q || (cnt_q == '0);
  assign start     = baud_tick && cts && have_req && slot_free;
  assign pop       = start && (src == SRC_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_pend_q  <= 1'b0;
      sync_pend_q <= 1'b0;
    end else begin
      if (start && src == SRC_BREAK) brk_pend_q <= 1'b0;
      else if (send_break)           brk_pend_q <= 1'b1;
      if (start && src == SRC_SYNC)  sync_pend_q <= 1'b0;
      else if (send_sync)            sync_pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      line_q <= 1'b1;
      sh_q   <= '1;
      cnt_q  <= '0;
    end else if (baud_tick) begin
      if (start) begin
        busy_q <= 1'b1;
        line_q <= 1'b0;
        sh_q   <= fr_bits;
        cnt_q  <= fr_len;
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          line_q <= 1'b1;
        end else begin
          line_q <= sh_q[0];
          sh_q   <= {1'b1, sh_q[SH_W-1:1]};
          cnt_q  <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  assign s_ready = !full;
  assign tx_out  = line_q;
  assign tx_busy = busy_q;
  assign tx_irq  = irq_sel ? empty : !full;

  p_idle_line_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> line_q);
  p_bit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(baud_tick) |-> $stable(line_q));
  p_start_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(cts));
  p_break_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !brk_pend_q);
endmodule

// File: tb/uart_tx_flow_tb_top.sv
module uart_tx_flow_tb_top;
  localparam int BRK = 13;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0;
  logic [8:0] s_data = '0;
  logic       cts = 1'b0;
  logic       cfg_nine_bit = 1'b0;
  logic [1:0] cfg_parity = 2'b00;
  logic       cfg_two_stop = 1'b0;
  logic       irq_sel = 1'b0;
  logic       send_break = 1'b0;
  logic       send_sync = 1'b0;
  logic       s_ready, tx_out, tx_busy, tx_irq;
  logic [1:0] tdiv;
  logic       baud_tick;
  int         tick_no;
  int         n_run = 0;
  int         n_fail = 0;
  int         t_start, t_end, prev_end;

  always #5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdiv    <= '0;
      tick_no <= 0;
    end else begin
      tdiv    <= tdiv + 2'd1;
      tick_no <= tick_no + (baud_tick ? 1 : 0);
    end
  end
  assign baud_tick = (tdiv == 2'd3);

  uart_tx_flow #(.DEPTH(4), .BREAK_BITS(BRK)) dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .cts(cts), .cfg_nine_bit(cfg_nine_bit),
    .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop), .irq_sel(irq_sel),
    .send_break(send_break), .send_sync(send_sync), .tx_out(tx_out),
    .tx_busy(tx_busy), .tx_irq(tx_irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic int build(input logic [8:0] d, input logic nine,
                               input logic [1:0] par, input logic two,
                               output logic [15:0] v);
    int n = 0;
    v = '0;
    for (int i = 0; i < 8; i++) begin v[n] = d[i]; n++; end
    if (nine) begin v[n] = d[8]; n++; end
    else if (par == 2'b01) begin v[n] = ^d[7:0]; n++; end
    else if (par == 2'b10) begin v[n] = ~^d[7:0]; n++; end
    v[n] = 1'b1; n++;
    if (two) begin v[n] = 1'b1; n++; end
    return n;
  endfunction

  task automatic push_word(input logic [8:0] d);
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = d;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic pulse(input bit brk);
    @(negedge clk);
    if (brk) send_break = 1'b1; else send_sync = 1'b1;
    @(negedge clk);
    send_break = 1'b0;
    send_sync  = 1'b0;
  endtask

  task automatic wait_start();
    do @(negedge clk); while (!(baud_tick && tx_out == 1'b0));
    t_start = tick_no;
  endtask

  task automatic capture(input string req, input logic [15:0] v, input int n);
    logic [15:0] got = '0;
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!baud_tick);
      got[i] = tx_out;
    end
    t_end = tick_no;
    chk(req, {16'h0, got}, {16'h0, v});
  endtask

  task automatic check_frame(input string req, input logic [15:0] v, input int n);
    wait_start();
    capture(req, v, n);
  endtask

  task automatic check_data(input string req, input logic [8:0] d);
    logic [15:0] v;
    int n;
    n = build(d, cfg_nine_bit, cfg_parity, cfg_two_stop, v);
    check_frame(req, v, n);
  endtask

  task automatic idle_ticks(input int k);
    for (int i = 0; i < k; i++) do @(negedge clk); while (!baud_tick);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 line idle", {31'h0, tx_out}, 32'd1);
    chk("R1 busy", {31'h0, tx_busy}, 32'd0);
    chk("R1 ready", {31'h0, s_ready}, 32'd1);
  endtask

  task automatic t_plain();
    cts = 1'b1;
    push_word(9'h0A5); check_data("R2 8N1 A5", 9'h0A5);
    push_word(9'h001); check_data("R2 8N1 01", 9'h001);
    push_word(9'h080); check_data("R2 8N1 80", 9'h080);
    idle_ticks(2);
    chk("R1 idle after frames", {30'h0, tx_busy, tx_out}, 32'd1);
  endtask

  task automatic t_parity();
    cfg_parity = 2'b01;
    push_word(9'h007); check_data("R3 even odd-weight", 9'h007);
    push_word(9'h003); check_data("R3 even even-weight", 9'h003);
    cfg_parity = 2'b10;
    push_word(9'h007); check_data("R3 odd odd-weight", 9'h007);
    push_word(9'h003); check_data("R3 odd even-weight", 9'h003);
    cfg_parity = 2'b11;
    push_word(9'h007); check_data("R3 reserved no parity", 9'h007);
    cfg_parity = 2'b00;
  endtask

  task automatic t_nine();
    cfg_nine_bit = 1'b1;
    cfg_parity   = 2'b01;
    push_word(9'h1C3); check_data("R4 nine bit high", 9'h1C3);
    push_word(9'h0C3); check_data("R4 nine bit low", 9'h0C3);
    cfg_nine_bit = 1'b0;
    cfg_parity   = 2'b00;
  endtask

  task automatic t_two_stop();
    cfg_two_stop = 1'b1;
    push_word(9'h05A); check_data("R5 two stop", 9'h05A);
    cfg_two_stop = 1'b0;
  endtask

  task automatic t_fifo();
    logic [8:0] w;
    cts = 1'b0;
    irq_sel = 1'b1;
    @(negedge clk);
    chk("R11 empty irq sel1", {31'h0, tx_irq}, 32'd1);
    push_word(9'h011);
    @(negedge clk);
    chk("R11 nonempty irq sel1", {31'h0, tx_irq}, 32'd0);
    irq_sel = 1'b0;
    @(negedge clk);
    chk("R11 free slot irq sel0", {31'h0, tx_irq}, 32'd1);
    push_word(9'h022); push_word(9'h033); push_word(9'h044);
    @(negedge clk);
    chk("R6 full ready low", {31'h0, s_ready}, 32'd0);
    chk("R11 full irq sel0", {31'h0, tx_irq}, 32'd0);
    idle_ticks(3);
    chk("R7 held by cts", {30'h0, tx_busy, tx_out}, 32'd1);
    cts = 1'b1;
    for (int i = 0; i < 4; i++) begin
      w = 9'(8'h11 * (i + 1));
      check_data("R6 order", w);
      if (i > 0) chk("R12 back to back", t_start, prev_end + 1);
      prev_end = t_end;
    end
  endtask

  task automatic t_cts();
    logic [15:0] v;
    int n;
    cts = 1'b0;
    push_word(9'h00F); push_word(9'h0F0);
    cts = 1'b1;
    wait_start();
    cts = 1'b0;
    n = build(9'h00F, 1'b0, 2'b00, 1'b0, v);
    capture("R7 frame completes", v, n);
    idle_ticks(4);
    chk("R7 no start while low", {30'h0, tx_busy, tx_out}, 32'd1);
    cts = 1'b1;
    check_data("R7 resumes", 9'h0F0);
  endtask

  task automatic t_break_sync();
    logic [15:0] v;
    int n;
    cts = 1'b1;
    pulse(1'b1);
    check_frame("R8 break", 16'h1 << (BRK - 1), BRK);
    cfg_nine_bit = 1'b1; cfg_parity = 2'b01; cfg_two_stop = 1'b1;
    pulse(1'b0);
    n = build(9'h055, 1'b0, 2'b01, 1'b1, v);
    check_frame("R9 sync", v, n);
    cfg_nine_bit = 1'b0; cfg_parity = 2'b00; cfg_two_stop = 1'b0;
  endtask

  task automatic t_priority();
    logic [15:0] v;
    int n;
    cts = 1'b0;
    push_word(9'h03C);
    pulse(1'b0);
    pulse(1'b1);
    pulse(1'b1);
    cts = 1'b1;
    check_frame("R10 break first", 16'h1 << (BRK - 1), BRK);
    n = build(9'h055, 1'b0, 2'b00, 1'b0, v);
    check_frame("R10 sync second", v, n);
    check_data("R10 data last", 9'h03C);
    idle_ticks(3);
    chk("R10 merged break", {30'h0, tx_busy, tx_out}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_parity();
    t_nine();
    t_two_stop();
    t_fifo();
    t_cts();
    t_break_sync();
    t_priority();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule